// File: doc/BRIEF.md
# Downstream Write Frame Builder and Serializer

This block feeds the command/write direction of a serial memory channel. Each frame starts as a request with three parts: a 2-bit frame type, a 24-bit command and a 72-bit field. Depending on the type, the field holds data, half data and one extra command, or two extra commands. The block does not interpret the field. It packs the three parts into a 98-bit payload and computes a 22-bit CRC over that payload. The result is a 120-bit frame, which leaves on ten lanes over twelve consecutive beats. The block sends frames without pause, whether or not requests arrive. When no request is pending, it sends an idle frame that carries a valid CRC.

Requests use a valid/ready handshake. The producer may raise `req_valid` at any time. It must then hold `req_valid` and its fields until it sees `req_ready`. The block raises `req_ready` for exactly one cycle out of every twelve: the last beat of the frame in flight. A request is taken only on a cycle where both signals are high. So each frame can carry at most one request, and a producer that keeps `req_valid` high gets frames back to back with no idle frame between them. The values on the request fields at any other cycle have no effect.

Top module: `wr_frame_tx`

## Requirements
- R1: After reset is released, the first cycle is beat 0 of an idle frame, and `frame_start` is high in that cycle.
- R2: The payload places the type in bits [1:0], the command in bits [25:2] and the 72-bit field in bits [97:26].
- R3: Frame bits [119:98] hold a CRC over the 98 payload bits. The CRC uses generator 0x2F3A1D (x^22 implied), starts with all ones, processes bit 97 first, and has no final inversion.
- R4: In beat k (0 to 11), lane i carries frame bit 10k+i. Beats run 0..11 and then restart at 0 with no gap.
- R5: `req_ready` is high only in beat 11. `frame_start` is high only in beat 0.
- R6: A request taken in beat 11 goes out as the frame whose beat 0 is the next cycle. A producer that keeps `req_valid` high gets consecutive frames with no idle frame between them.
- R7: The request fields are sampled only in the accepting cycle. Changes made earlier in the frame do not affect the frame that is sent.
- R8: If no request is taken in beat 11, the next frame is idle: type 00, command all zeros (the no-op), field all zeros, and a valid CRC per R3.
- R9: The 72-bit field is sent unchanged for type 01 (data), 10 (half data plus command) and 11 (two commands), and also for a type 00 request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one beat per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A frame request is offered |
| req_ready | output | 1 | High in beat 11; the request is taken when this and `req_valid` are both high |
| req_type | input | 2 | Frame type: 00 idle/command only, 01 data, 10 half data plus command, 11 two commands |
| req_cmd | input | 24 | Command field |
| req_field | input | 72 | Data or extra-command field |
| frame_start | output | 1 | High in beat 0 of each frame |
| lane_o | output | 10 | Lane values for the current beat |

## Verification
The assertions check the following on every cycle:
- The beat counter wraps from 11 to 0.
- A ready beat is always followed by a frame start.
- The shift register moves down by exactly one lane group per beat.
- An accepted request's type and low command bits appear on the lanes in the next beat, and an unclaimed ready beat gives type 00.

Only the bench's scenarios can show the rest:
- Whole-frame contents, including the CRC bits in the last beats.
- That field contents pass through unchanged for every type.
- That changes to the request fields before the accepting beat are ignored.

// File: rtl/wft_pkg.sv
package wft_pkg;
  localparam int LANES    = 10;
  localparam int BEATS    = 12;
  localparam int TYPE_W   = 2;
  localparam int CMD_W    = 24;
  localparam int FIELD_W  = 72;
  localparam int CRC_W    = 22;
  localparam int PAYLOAD_W = TYPE_W + CMD_W + FIELD_W;
  localparam int FRAME_W   = PAYLOAD_W + CRC_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 22'h2F3A1D;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;
  localparam logic [CMD_W-1:0] CMD_NOP  = '0;

  typedef enum logic [TYPE_W-1:0] {
    FT_IDLE = 2'b00,
    FT_DATA = 2'b01,
    FT_HALF = 2'b10,
    FT_DUAL = 2'b11
  } ftype_e;
endpackage

// File: rtl/wft_pack.sv
module wft_pack
  import wft_pkg::*;
#(
  parameter int TW = TYPE_W,
  parameter int CW = CMD_W,
  parameter int FW = FIELD_W,
  localparam int PW = TW + CW + FW
) (
  input  logic          use_req,
  input  logic [TW-1:0] in_type,
  input  logic [CW-1:0] in_cmd,
  input  logic [FW-1:0] in_field,
  output logic [PW-1:0] payload
);
  always_comb begin
    if (use_req) begin
      payload = {in_field, in_cmd, in_type};
    end else begin
      payload = {{FW{1'b0}}, CW'(CMD_NOP), TW'(FT_IDLE)};
    end
  end
endmodule

// File: rtl/wft_crc.sv
module wft_crc
  import wft_pkg::*;
#(
  parameter int DW = PAYLOAD_W,
  parameter int RW = CRC_W,
  parameter logic [RW-1:0] POLY = CRC_POLY,
  parameter logic [RW-1:0] SEED = CRC_SEED
) (
  input  logic [DW-1:0] data,
  output logic [RW-1:0] crc
);
  logic [RW-1:0] stage [0:DW];
  assign stage[0] = SEED;

  for (genvar g = 0; g < DW; g++) begin : g_step
    logic fb;
    assign fb = stage[g][RW-1] ^ data[DW-1-g];
    assign stage[g+1] = {stage[g][RW-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc = stage[DW];
endmodule

// File: rtl/wft_ser.sv
module wft_ser
  import wft_pkg::*;
#(
  parameter int LN = LANES,
  parameter int NB = BEATS,
  localparam int FW = LN * NB,
  localparam int CNT_W = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] frame_in,
  output logic          beat_first,
  output logic          beat_last,
  output logic [LN-1:0] lanes
);
  logic [CNT_W-1:0] beat_q;
  logic [FW-1:0]    shreg_q;
  logic             load;

  assign beat_first = (beat_q == '0);
  assign beat_last  = (beat_q == CNT_W'(NB - 1));
  assign load       = beat_last || !rst_n;
  assign lanes      = shreg_q[LN-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || beat_last) beat_q <= '0;
    else                     beat_q <= beat_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (load) shreg_q <= frame_in;
    else      shreg_q <= {{LN{1'b0}}, shreg_q[FW-1:LN]};
  end

  // R4: counter returns to beat 0 after the last beat
  a_r4_beat_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> (beat_q == '0));

  // R4: one lane group drops out per beat inside a frame
  a_r4_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_last |=> (shreg_q[FW-LN-1:0] == $past(shreg_q[FW-1:LN])));
endmodule

// File: rtl/wr_frame_tx.sv
module wr_frame_tx
  import wft_pkg::*;
#(
  parameter int LN = LANES,
  parameter int NB = BEATS,
  parameter int TW = TYPE_W,
  parameter int CW = CMD_W,
  parameter int FLD_W = FIELD_W,
  parameter int RW = CRC_W,
  localparam int PW = TW + CW + FLD_W,
  localparam int FRW = PW + RW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TW-1:0]    req_type,
  input  logic [CW-1:0]    req_cmd,
  input  logic [FLD_W-1:0] req_field,
  output logic             frame_start,
  output logic [LN-1:0]    lane_o
);
  logic          take;
  logic [PW-1:0] payload;
  logic [RW-1:0] crc;
  logic [FRW-1:0] frame;

  assign take = req_valid && req_ready;

  wft_pack #(.TW(TW), .CW(CW), .FW(FLD_W)) u_pack (
    .use_req (take),
    .in_type (req_type),
    .in_cmd  (req_cmd),
    .in_field(req_field),
    .payload (payload)
  );

  wft_crc #(.DW(PW), .RW(RW)) u_crc (
    .data(payload),
    .crc (crc)
  );

  assign frame = {crc, payload};

  wft_ser #(.LN(LN), .NB(NB)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_in  (frame),
    .beat_first(frame_start),
    .beat_last (req_ready),
    .lanes     (lane_o)
  );

  // R5/R6: a ready beat is followed directly by a frame start
  a_r6_ready_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> frame_start);

  // R2/R6: an accepted request's type and low command bits lead the next frame
  a_r2_accept_leads: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (lane_o[TW-1:0] == $past(req_type)) &&
             (lane_o[LN-1:TW] == $past(req_cmd[LN-TW-1:0])));

  // R8: an unclaimed ready beat yields an idle type
  a_r8_idle_type: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> (lane_o[TW-1:0] == TW'(FT_IDLE)));
endmodule

// File: tb/wr_frame_tx_bench.sv
module wr_frame_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_type = '0;
  logic [23:0] req_cmd = '0;
  logic [71:0] req_field = '0;
  logic        frame_start;
  logic [9:0]  lane_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wr_frame_tx u_wr_frame_tx (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_cmd(req_cmd), .req_field(req_field),
    .frame_start(frame_start), .lane_o(lane_o)
  );

  localparam int NV = 5;
  // payload vectors {field, cmd, type}
  localparam logic [97:0] VEC [0:NV-1] = '{
    {72'h0123456789ABCDEF01, 24'hA5C3E1, 2'b01},
    {72'hFEDCBA9876543210FF, 24'h13579B, 2'b10},
    {72'h800000000000000001, 24'h800001, 2'b11},
    {72'h3C3C3C3C3C3C3C3C3C, 24'h0F0F0F, 2'b00},
    {72'hFFFFFFFFFFFFFFFFFF, 24'hFFFFFF, 2'b01}
  };

  function automatic logic [119:0] expect_frame(input logic [97:0] p);
    logic [21:0] r;
    r = 22'h3FFFFF;
    for (int i = 97; i >= 0; i--) begin
      if (r[21] ^ p[i]) r = (r << 1) ^ 22'h2F3A1D;
      else              r = r << 1;
    end
    return {r, p};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [119:0] act, input logic [119:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [97:0] p);
    req_valid = v;
    req_type  = p[1:0];
    req_cmd   = p[25:2];
    req_field = p[97:26];
  endtask

  // called at the negedge of beat 0; returns at the negedge of the next beat 0
  task automatic capture(output logic [119:0] f, output bit timing_ok,
                         input bit chg, input logic [97:0] chg_p);
    timing_ok = 1'b1;
    f = '0;
    for (int k = 0; k < 12; k++) begin
      f[10*k +: 10] = lane_o;
      if (req_ready !== (k == 11)) timing_ok = 1'b0;
      if (frame_start !== (k == 0)) timing_ok = 1'b0;
      if (chg && k == 5) drive(1'b1, chg_p);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [119:0] f, e;
    bit tok;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first frame after reset is idle
    capture(f, tok, 1'b0, '0);
    e = expect_frame('0);
    check(f == e, "R1 idle after reset", f, e);
    check(tok, "R5 ready/start timing", {119'b0, tok}, 120'b1);

    // request arrives late for this frame -> idle frame first (R8)
    drive(1'b1, VEC[0]);
    capture(f, tok, 1'b0, '0);
    check(f == e, "R8 idle when none taken", f, e);

    for (int v = 0; v < NV; v++) begin
      if (v + 1 < NV) drive(1'b1, VEC[v+1]);
      else            drive(1'b0, '0);
      capture(f, tok, 1'b0, '0);
      e = expect_frame(VEC[v]);
      check(f == e, "R6 R3 R4 back-to-back frame", f, e);
      check(f[97:26] == VEC[v][97:26], "R9 field passthrough", {48'b0, f[97:26]}, {48'b0, VEC[v][97:26]});
      check(f[1:0] == VEC[v][1:0] && f[25:2] == VEC[v][25:2], "R2 type/cmd position",
            {94'b0, f[25:0]}, {94'b0, VEC[v][25:0]});
      check(tok, "R5 ready/start timing", {119'b0, tok}, 120'b1);
    end

    // after the stream ends: idle frame (R8)
    capture(f, tok, 1'b0, '0);
    e = expect_frame('0);
    check(f == e, "R8 idle after stream", f, e);

    // R7: fields changed mid-frame; only accept-cycle values count
    drive(1'b1, VEC[1]);
    capture(f, tok, 1'b1, VEC[2]);
    check(f == e, "R7 idle frame untouched by early request", f, e);
    drive(1'b0, VEC[3]);
    capture(f, tok, 1'b0, '0);
    e = expect_frame(VEC[2]);
    check(f == e, "R7 sampled at accept", f, e);
    capture(f, tok, 1'b0, '0);
    e = expect_frame('0);
    check(f == e, "R8 valid low gives idle", f, e);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule